// File: doc/BRIEF.md
# Two-Cell Battery Protection Controller

This block is the decision core of a protector for a pack of two series battery cells. It takes two digitized cell voltages in millivolts and a sample strobe from the converter that produces them. On each strobe it compares every cell against a set of thresholds and moves between five states: off, normal, overvoltage, undervoltage/sleep, and a terminal split-fault state. The split-fault state is entered when one cell is overcharged while the other is over-discharged. Every output is registered. The outputs are the permit lines for the pass switch in the charge and discharge directions, active-low overvoltage and undervoltage status flags, a low-power warning, a sleep indication and a sticky kill latch.

The overvoltage fault and the undervoltage fault each have their own release level, so a cell voltage that sags or recovers under load cannot make the switch oscillate. An active-high run input gates the whole controller. While it is low, the switch is held off and the kill latch is cleared, which is how the pack is armed at assembly time. A separate check on the summed pack voltage returns the controller to its off state whenever the pack is too low to power it.

Top module: `pack_guard`

## Requirements
- R1: While rst_n is low, and on every clock edge at which run_en is low, the outputs become chg_en=0, dsg_en=0, ov_n=1, uv_n=1, low_warn=0, sleep=0, kill=0 (off state). Raising run_en changes nothing until the next strobe.
- R2: When a strobe finds no cell above 4250 mV, no cell below 2500 mV and a pack sum of at least 3700 mV, and the state is off or normal, the result is normal: chg_en=1, dsg_en=1, ov_n=1, uv_n=1, sleep=0.
- R3: A strobe that finds any cell strictly above 4250 mV, from off or normal and with no cell below 2500 mV, enters overvoltage: ov_n=0, uv_n=1, chg_en=0, dsg_en=1.
- R4: Overvoltage is left for normal only by a strobe on which every cell is strictly below 3750 mV. A cell at exactly 3750 mV keeps the state.
- R5: kill rises on the strobe that enters overvoltage from any other state. It then stays 1 through every state, including the under-supply off state, until run_en is low at a clock edge.
- R6: After a strobe whose resulting state is normal or overvoltage, low_warn=1 exactly when some cell is strictly below 3000 mV. In every other state, low_warn=0.
- R7: A strobe that finds any cell strictly below 2500 mV, from off or normal and with no cell above 4250 mV, enters undervoltage: uv_n=0, ov_n=1, chg_en=1, dsg_en=0, sleep=1, low_warn=0. A cell at exactly 2500 mV does not trip.
- R8: Undervoltage is left for normal only by a strobe on which every cell is strictly above 3000 mV. A cell at exactly 3000 mV keeps the state.
- R9: A strobe that finds one cell above 4250 mV and another below 2500 mV enters the split fault from any state: ov_n=0, uv_n=0, chg_en=0, dsg_en=0. Only a low run_en or an under-supply strobe leaves it.
- R10: A strobe on which the cell sum is strictly below 3700 mV forces the off-state outputs of R1, with kill kept. This has priority over every other rule. The next strobe is judged as from normal, so a sum of exactly 3700 mV counts as powered.
- R11: With run_en high, the outputs do not change at a clock edge where sample_en is low, whatever the cell inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Controller enable; low holds the switch off and clears kill |
| sample_en | input | 1 | One-cycle strobe marking fresh cell voltages |
| cells_mv | input | N_CELLS*MV_W (32) | Cell voltages in mV; cell i at bits [i*MV_W +: MV_W] |
| chg_en | output | 1 | Charge-direction permit for the pass switch |
| dsg_en | output | 1 | Discharge-direction permit for the pass switch |
| ov_n | output | 1 | Overvoltage status, low when overcharged |
| uv_n | output | 1 | Undervoltage status, low when over-discharged |
| low_warn | output | 1 | Low-power warning |
| sleep | output | 1 | Sleep indication in undervoltage |
| kill | output | 1 | Sticky kill latch |

## Verification
The hardest situation to reach from the ports is the split fault held together with a pending kill. It needs one cell above the overvoltage trip and the other below the undervoltage trip on the same strobe, while the pack sum stays above the supply floor. It then has to be left through the supply floor and not through run_en. Random draws seldom meet all of these conditions at once, so a directed sequence first enters overvoltage to set kill, then applies a 4300/2400 mV pair, then drops the sum to 3600 mV and then to exactly 3700 mV. Random strobes weighted toward values one millivolt either side of each threshold, with occasional run_en pulses to escape the terminal state, cover the remaining transitions.

// File: rtl/pg_pkg.sv
package pg_pkg;

   typedef enum logic [2:0] {
      PG_OFF   = 3'd0,
      PG_NORM  = 3'd1,
      PG_OVER  = 3'd2,
      PG_UNDER = 3'd3,
      PG_SPLIT = 3'd4
   } pg_state_e;

   // per-cell threshold results
   typedef struct packed {
      logic hi_trip;   // above overvoltage trip
      logic hi_rel;    // below overvoltage release
      logic warn;      // below warning level
      logic lo_trip;   // below undervoltage trip
      logic lo_rel;    // above undervoltage release
   } pg_cmp_t;

   typedef struct packed {
      logic chg;
      logic dsg;
      logic ov_n;
      logic uv_n;
      logic sleep;
   } pg_drive_t;

   function automatic pg_drive_t pg_drive(input pg_state_e s);
      pg_drive_t d;
      case (s)
         PG_NORM:  d = '{chg: 1'b1, dsg: 1'b1, ov_n: 1'b1, uv_n: 1'b1, sleep: 1'b0};
         PG_OVER:  d = '{chg: 1'b0, dsg: 1'b1, ov_n: 1'b0, uv_n: 1'b1, sleep: 1'b0};
         PG_UNDER: d = '{chg: 1'b1, dsg: 1'b0, ov_n: 1'b1, uv_n: 1'b0, sleep: 1'b1};
         PG_SPLIT: d = '{chg: 1'b0, dsg: 1'b0, ov_n: 1'b0, uv_n: 1'b0, sleep: 1'b0};
         default:  d = '{chg: 1'b0, dsg: 1'b0, ov_n: 1'b1, uv_n: 1'b1, sleep: 1'b0};
      endcase
      return d;
   endfunction

endpackage

// File: rtl/pg_cell_cmp.sv
module pg_cell_cmp
   import pg_pkg::*;
#(
   parameter int MV_W   = 16,
   parameter int HI_SET = 4250,
   parameter int HI_CLR = 3750,
   parameter int WARN   = 3000,
   parameter int LO_SET = 2500,
   parameter int LO_CLR = 3000
) (
   input  logic [MV_W-1:0] mv,
   output pg_cmp_t         flags
);

   localparam logic [MV_W-1:0] T_HI_SET = MV_W'(HI_SET);
   localparam logic [MV_W-1:0] T_HI_CLR = MV_W'(HI_CLR);
   localparam logic [MV_W-1:0] T_WARN   = MV_W'(WARN);
   localparam logic [MV_W-1:0] T_LO_SET = MV_W'(LO_SET);
   localparam logic [MV_W-1:0] T_LO_CLR = MV_W'(LO_CLR);

   always_comb begin
      flags.hi_trip = (mv > T_HI_SET);
      flags.hi_rel  = (mv < T_HI_CLR);
      flags.warn    = (mv < T_WARN);
      flags.lo_trip = (mv < T_LO_SET);
      flags.lo_rel  = (mv > T_LO_CLR);
   end

endmodule

// File: rtl/pg_supply_mon.sv
module pg_supply_mon #(
   parameter int N_CELLS    = 2,
   parameter int MV_W       = 16,
   parameter int SUPPLY_MIN = 3700
) (
   input  logic [N_CELLS*MV_W-1:0] cells_mv,
   output logic                    low_supply
);

   localparam int SUM_W = MV_W + $clog2(N_CELLS) + 1;
   localparam logic [SUM_W-1:0] T_MIN = SUM_W'(SUPPLY_MIN);

   logic [SUM_W-1:0] total;

   always_comb begin
      total = '0;
      for (int i = 0; i < N_CELLS; i++) begin
         total = total + SUM_W'(cells_mv[i*MV_W +: MV_W]);
      end
      low_supply = (total < T_MIN);
   end

endmodule

// File: rtl/pg_seq.sv
module pg_seq
   import pg_pkg::*;
#(
   parameter int N_CELLS = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  run_en,
   input  logic                  strobe,
   input  pg_cmp_t [N_CELLS-1:0] cmp,
   input  logic                  low_supply,
   output pg_state_e             nxt,
   output logic                  warn_q,
   output logic                  kill_q
);

   pg_state_e state_q;
   pg_state_e eval;
   logic any_hi, any_lo, any_warn, all_hi_rel, all_lo_rel;
   logic warn_d, kill_d;

   always_comb begin
      any_hi     = 1'b0;
      any_lo     = 1'b0;
      any_warn   = 1'b0;
      all_hi_rel = 1'b1;
      all_lo_rel = 1'b1;
      for (int i = 0; i < N_CELLS; i++) begin
         any_hi     = any_hi     | cmp[i].hi_trip;
         any_lo     = any_lo     | cmp[i].lo_trip;
         any_warn   = any_warn   | cmp[i].warn;
         all_hi_rel = all_hi_rel & cmp[i].hi_rel;
         all_lo_rel = all_lo_rel & cmp[i].lo_rel;
      end
   end

   // decision for a strobe; supply floor first, then split fault
   always_comb begin
      eval = state_q;
      if (low_supply) begin
         eval = PG_OFF;
      end else if (any_hi && any_lo) begin
         eval = PG_SPLIT;
      end else begin
         case (state_q)
            PG_OFF, PG_NORM: begin
               if (any_hi)      eval = PG_OVER;
               else if (any_lo) eval = PG_UNDER;
               else             eval = PG_NORM;
            end
            PG_OVER:  eval = all_hi_rel ? PG_NORM : PG_OVER;
            PG_UNDER: eval = all_lo_rel ? PG_NORM : PG_UNDER;
            PG_SPLIT: eval = PG_SPLIT;
            default:  eval = PG_OFF;
         endcase
      end
   end

   always_comb begin
      nxt    = state_q;
      warn_d = warn_q;
      kill_d = kill_q;
      if (!run_en) begin
         nxt    = PG_OFF;
         warn_d = 1'b0;
         kill_d = 1'b0;
      end else if (strobe) begin
         nxt    = eval;
         warn_d = ((eval == PG_NORM) || (eval == PG_OVER)) && any_warn;
         if ((eval == PG_OVER) && (state_q != PG_OVER)) kill_d = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= PG_OFF;
         warn_q  <= 1'b0;
         kill_q  <= 1'b0;
      end else begin
         state_q <= nxt;
         warn_q  <= warn_d;
         kill_q  <= kill_d;
      end
   end

endmodule

// File: rtl/pg_outreg.sv
module pg_outreg
   import pg_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  pg_state_e nxt,
   output pg_drive_t drv_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) drv_q <= pg_drive(PG_OFF);
      else        drv_q <= pg_drive(nxt);
   end

endmodule

// File: rtl/pack_guard.sv
module pack_guard
   import pg_pkg::*;
#(
   parameter int N_CELLS      = 2,
   parameter int MV_W         = 16,
   parameter int HI_SET_MV    = 4250,
   parameter int HI_CLR_MV    = 3750,
   parameter int WARN_MV      = 3000,
   parameter int LO_SET_MV    = 2500,
   parameter int LO_CLR_MV    = 3000,
   parameter int SUPPLY_MIN   = 3700,
   parameter bit SUPPLY_CHECK = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    run_en,
   input  logic                    sample_en,
   input  logic [N_CELLS*MV_W-1:0] cells_mv,
   output logic                    chg_en,
   output logic                    dsg_en,
   output logic                    ov_n,
   output logic                    uv_n,
   output logic                    low_warn,
   output logic                    sleep,
   output logic                    kill
);

   localparam int MV_MAX = (1 << MV_W) - 1;

   if (N_CELLS < 2) begin : g_bad_cells
      $error("pack_guard: N_CELLS must be at least 2");
   end
   if (HI_CLR_MV >= HI_SET_MV) begin : g_bad_hi
      $error("pack_guard: overvoltage release must sit below its trip");
   end
   if (LO_CLR_MV <= LO_SET_MV) begin : g_bad_lo
      $error("pack_guard: undervoltage release must sit above its trip");
   end
   if (HI_SET_MV > MV_MAX) begin : g_bad_width
      $error("pack_guard: MV_W too narrow for the thresholds");
   end
   if (!(WARN_MV > LO_SET_MV && WARN_MV < HI_CLR_MV)) begin : g_bad_warn
      $error("pack_guard: warning level must lie between the trips");
   end

   pg_cmp_t [N_CELLS-1:0] cmp;
   logic                  low_supply;
   pg_state_e             nxt;
   pg_drive_t             drv;

   for (genvar i = 0; i < N_CELLS; i++) begin : g_cell
      pg_cell_cmp #(
         .MV_W   (MV_W),
         .HI_SET (HI_SET_MV),
         .HI_CLR (HI_CLR_MV),
         .WARN   (WARN_MV),
         .LO_SET (LO_SET_MV),
         .LO_CLR (LO_CLR_MV)
      ) u_cmp (
         .mv    (cells_mv[i*MV_W +: MV_W]),
         .flags (cmp[i])
      );
   end

   if (SUPPLY_CHECK) begin : g_supply
      pg_supply_mon #(
         .N_CELLS    (N_CELLS),
         .MV_W       (MV_W),
         .SUPPLY_MIN (SUPPLY_MIN)
      ) u_mon (
         .cells_mv   (cells_mv),
         .low_supply (low_supply)
      );
   end else begin : g_no_supply
      assign low_supply = 1'b0;
   end

   pg_seq #(
      .N_CELLS (N_CELLS)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .run_en     (run_en),
      .strobe     (sample_en),
      .cmp        (cmp),
      .low_supply (low_supply),
      .nxt        (nxt),
      .warn_q     (low_warn),
      .kill_q     (kill)
   );

   pg_outreg u_out (
      .clk   (clk),
      .rst_n (rst_n),
      .nxt   (nxt),
      .drv_q (drv)
   );

   assign chg_en = drv.chg;
   assign dsg_en = drv.dsg;
   assign ov_n   = drv.ov_n;
   assign uv_n   = drv.uv_n;
   assign sleep  = drv.sleep;

endmodule

// File: rtl/pg_checker.sv
module pg_checker #(
   parameter int N_CELLS    = 2,
   parameter int MV_W       = 16,
   parameter int SUPPLY_MIN = 3700
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    run_en,
   input logic                    sample_en,
   input logic [N_CELLS*MV_W-1:0] cells_mv,
   input logic                    chg_en,
   input logic                    dsg_en,
   input logic                    ov_n,
   input logic                    uv_n,
   input logic                    low_warn,
   input logic                    sleep,
   input logic                    kill
);

   localparam int SUM_W = MV_W + $clog2(N_CELLS) + 1;
   logic [SUM_W-1:0] sum_mv;
   logic             under_fed;

   always_comb begin
      sum_mv = '0;
      for (int i = 0; i < N_CELLS; i++) sum_mv = sum_mv + SUM_W'(cells_mv[i*MV_W +: MV_W]);
      under_fed = (sum_mv < SUM_W'(SUPPLY_MIN));
   end

   // R1
   hold_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run_en |=> (!chg_en && !dsg_en && ov_n && uv_n && !low_warn && !sleep && !kill));

   // R2
   norm_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ov_n && uv_n && (chg_en || dsg_en)) |-> (chg_en && dsg_en && !sleep));

   // R3
   ov_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ov_n && uv_n) |-> (!chg_en && dsg_en && !sleep));

   // R5
   kill_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(ov_n) && uv_n) |-> kill);

   // R5
   kill_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (kill && run_en) |=> kill);

   // R7
   uv_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ov_n && !uv_n) |-> (chg_en && !dsg_en && sleep && !low_warn));

   // R9
   split_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ov_n && !uv_n && run_en && !(sample_en && under_fed))
      |=> (!ov_n && !uv_n && !chg_en && !dsg_en));

   // R10
   supply_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run_en && sample_en && under_fed)
      |=> (!chg_en && !dsg_en && ov_n && uv_n && !sleep && !low_warn));

   // R11
   quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run_en && !sample_en)
      |=> $stable({chg_en, dsg_en, ov_n, uv_n, low_warn, sleep, kill}));

endmodule

bind pack_guard pg_checker #(
   .N_CELLS    (N_CELLS),
   .MV_W       (MV_W),
   .SUPPLY_MIN (SUPPLY_MIN)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .run_en    (run_en),
   .sample_en (sample_en),
   .cells_mv  (cells_mv),
   .chg_en    (chg_en),
   .dsg_en    (dsg_en),
   .ov_n      (ov_n),
   .uv_n      (uv_n),
   .low_warn  (low_warn),
   .sleep     (sleep),
   .kill      (kill)
);

// File: tb/pack_guard_tb.sv
`timescale 1ns/1ps
module pack_guard_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        run_en = 1'b0;
   logic        sample_en = 1'b0;
   logic [31:0] cells_mv = '0;
   logic        chg_en, dsg_en, ov_n, uv_n, low_warn, sleep, kill;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   // model: 0 off, 1 normal, 2 over, 3 under, 4 split
   int m_st = 0;
   bit m_kill = 1'b0;
   bit m_warn = 1'b0;

   always #2 clk = ~clk;

   pack_guard u_dut (
      .clk(clk), .rst_n(rst_n), .run_en(run_en), .sample_en(sample_en),
      .cells_mv(cells_mv), .chg_en(chg_en), .dsg_en(dsg_en), .ov_n(ov_n),
      .uv_n(uv_n), .low_warn(low_warn), .sleep(sleep), .kill(kill)
   );

   function automatic logic [6:0] exp_vec();
      logic [4:0] d;
      case (m_st)
         1: d = 5'b11110;
         2: d = 5'b01010;
         3: d = 5'b10101;
         4: d = 5'b00000;
         default: d = 5'b00110;
      endcase
      // order: chg dsg ov_n uv_n warn sleep kill
      return {d[4:1], m_warn, d[0], m_kill};
   endfunction

   function automatic void model_step(input int a, input int b);
      int ns;
      bit hi, lo;
      hi = (a > 4250) || (b > 4250);
      lo = (a < 2500) || (b < 2500);
      if (a + b < 3700)  ns = 0;
      else if (hi && lo) ns = 4;
      else begin
         case (m_st)
            2: ns = (a < 3750 && b < 3750) ? 1 : 2;
            3: ns = (a > 3000 && b > 3000) ? 1 : 3;
            4: ns = 4;
            default: ns = hi ? 2 : (lo ? 3 : 1);
         endcase
      end
      if (ns == 2 && m_st != 2) m_kill = 1'b1;
      m_warn = (ns == 1 || ns == 2) && (a < 3000 || b < 3000);
      m_st = ns;
   endfunction

   task automatic check(input string tag);
      logic [6:0] act;
      logic [6:0] ex;
      act = {chg_en, dsg_en, ov_n, uv_n, low_warn, sleep, kill};
      ex = exp_vec();
      checks++;
      if (act !== ex) begin
         errors++;
         $display("FAIL %s: actual=%b expected=%b (chg dsg ov_n uv_n warn sleep kill)", tag, act, ex);
      end
   endtask

   task automatic strobe(input int a, input int b, input string tag);
      cells_mv = {16'(b), 16'(a)};
      sample_en = 1'b1;
      @(posedge clk);
      @(negedge clk);
      sample_en = 1'b0;
      model_step(a, b);
      check(tag);
   endtask

   task automatic idle(input int n, input int a, input int b, input string tag);
      cells_mv = {16'(b), 16'(a)};
      repeat (n) @(posedge clk);
      @(negedge clk);
      check(tag);
   endtask

   task automatic disable_pulse(input string tag);
      run_en = 1'b0;
      @(posedge clk);
      @(negedge clk);
      m_st = 0; m_kill = 1'b0; m_warn = 1'b0;
      check(tag);
      run_en = 1'b1;
      @(posedge clk);
      @(negedge clk);
      check(tag);
   endtask

   function automatic int pick();
      int cand[16] = '{1000, 1700, 2400, 2499, 2500, 2600, 2999, 3000,
                       3001, 3500, 3749, 3750, 3800, 4250, 4251, 4400};
      int r;
      r = int'($urandom % 20);
      if (r < 16) return cand[r];
      return int'($urandom % 5000);
   endfunction

   function automatic string tag_of_state();
      case (m_st)
         1: return "R2/R6";
         2: return "R3/R4";
         3: return "R7/R8";
         4: return "R9";
         default: return "R10";
      endcase
   endfunction

   initial begin
      void'($urandom(32'd2718));
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R1 reset");
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 run_en low");
      run_en = 1'b1;
      idle(2, 3600, 3600, "R1 no strobe after release");

      strobe(3600, 3600, "R2 normal");
      strobe(2900, 3600, "R6 warn in normal");
      strobe(4251, 3600, "R3 enter over, R5 kill set");
      strobe(4250, 2900, "R6 warn in over");
      strobe(3750, 3000, "R4 3750 holds over");
      strobe(3749, 3700, "R4 release, R5 kill kept");
      idle(3, 4400, 2000, "R11 inputs ignored without strobe");
      strobe(2500, 3500, "R7 2500 does not trip");
      strobe(2499, 3500, "R7 enter under");
      strobe(3000, 3500, "R8 3000 holds under");
      strobe(3001, 3500, "R8 release");
      strobe(4300, 2400, "R9 enter split");
      strobe(3500, 3500, "R9 split terminal");
      strobe(1800, 1800, "R10 under-supply off, kill kept");
      strobe(1850, 1850, "R10 sum 3700 powered");
      strobe(3500, 3500, "R2 back to normal");
      disable_pulse("R1 R5 run_en low clears kill");
      strobe(2400, 4300, "R9 split from normal");
      disable_pulse("R9 left by run_en low");

      for (int it = 0; it < 2500; it++) begin
         if ($urandom % 100 < 6) begin
            disable_pulse("R1 random disable");
         end else begin
            int g;
            g = int'($urandom % 3);
            if (g > 0) idle(g, pick(), pick(), "R11 random idle");
            begin
               int a, b;
               a = pick();
               b = pick();
               strobe(a, b, tag_of_state());
            end
         end
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog R11: actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule